// File: doc/BRIEF.md
# Accumulator Adder/Subtractor Datapath

This block is a small register-based arithmetic unit. It holds a running value in an accumulator register and a second operand in an operand register that is filled from an external data bus. A single transfer strobe writes the adder result back into the accumulator. Two mode inputs decide what the adder sees from the operand register: the operand itself (addition), its bitwise complement with a carry-in of one (two's-complement subtraction), or zero (the accumulator passes through unchanged).

A typical accumulation runs as a sequence of strobes. A clear strobe zeroes the accumulator. The first operand is loaded, and a transfer in add mode places it in the accumulator. Each later load followed by a transfer folds in the next operand. Along with the result, the block registers a signed-overflow flag and the adder's carry-out. Both flags are sampled on every transfer and reset by a clear. The width is a parameter.

Top module: `accum_addsub`

## Requirements
- R1: A high `rst` at a rising edge sets the accumulator, the operand register and both flags to zero.
- R2: A high `ld_b` copies `data_in` into the operand register at the rising edge. A load alone leaves the accumulator and the flags unchanged.
- R3: A transfer with only `add_en` high stores (A + B) mod 2^N and sets `cout_q` to the unsigned carry out of the top bit. For example, clear, load 1001, transfer, load 0101, transfer gives A = 1110.
- R4: A transfer with `sub_en` high stores (A − B) mod 2^N, formed as A + ~B + 1. `cout_q` is 1 exactly when A ≥ B as unsigned numbers.
- R5: A transfer with both `add_en` and `sub_en` low leaves A unchanged and stores `ovf_q` = 0 and `cout_q` = 0.
- R6: When `add_en` and `sub_en` are both high, the block subtracts.
- R7: On a transfer, `ovf_q` is 1 exactly when the true signed result lies outside −2^(N−1) to 2^(N−1)−1. This means the two effective adder operands share a sign and the stored result has the other sign.
- R8: A high `clr` zeroes A and both flags and leaves B alone. When `clr` and `xfer` are high in the same cycle, the clear wins.
- R9: When `ld_b` and `xfer` are high in the same cycle, the sum uses the old B, and B takes the new bus word.
- R10: In a cycle with neither `xfer` nor `clr` high, A and both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| clr | input | 1 | Clear strobe for the accumulator and flags |
| ld_b | input | 1 | Load strobe for the operand register |
| xfer | input | 1 | Transfer strobe: adder result into accumulator |
| add_en | input | 1 | Select addition of the operand |
| sub_en | input | 1 | Select subtraction of the operand (has priority) |
| data_in | input | N | Data bus word for the operand register |
| acc_q | output | N | Accumulator contents |
| b_q | output | N | Operand register contents |
| ovf_q | output | 1 | Registered signed-overflow flag |
| cout_q | output | 1 | Registered adder carry-out |

## Verification
Two pairs of functions can collide in one cycle: a clear with a transfer, and an operand load with a transfer. The bench raises both strobes of a pair at the same falling edge. For the first pair it expects zeros in the accumulator and flags. For the second it expects the sum formed with the old operand, while the operand register shows the new word. The expected values come from a signed and unsigned integer model of the requirements, and cover the overflow boundaries in both directions and the case where both mode inputs are high.

// File: rtl/accum_pkg.sv
package accum_pkg;

    typedef enum logic [1:0] {
        OP_ZERO = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_e;

    typedef struct packed {
        logic ovf;
        logic cout;
    } acc_flags_t;

    localparam acc_flags_t FLAGS_NONE = '{ovf: 1'b0, cout: 1'b0};

    function automatic op_e pick_op(input logic add_req, input logic sub_req);
        if (sub_req)
            return OP_SUB;
        else if (add_req)
            return OP_ADD;
        else
            return OP_ZERO;
    endfunction

endpackage

// File: rtl/acc_operand_gate.sv
module acc_operand_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0]    b_in,
    input  accum_pkg::op_e  op,
    output logic [N-1:0]    b_eff,
    output logic            cin
);
    import accum_pkg::*;

    always_comb begin
        unique case (op)
            OP_ADD: begin
                b_eff = b_in;
                cin   = 1'b0;
            end
            OP_SUB: begin
                b_eff = ~b_in;
                cin   = 1'b1;
            end
            default: begin
                b_eff = '0;
                cin   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_bit_cell.sv
module acc_bit_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic         c_msb,
    output logic         ovf
);
    localparam int MSB = N - 1;

    logic [N:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_cell
        acc_bit_cell u_cell (
            .a  (a[i]),
            .b  (b[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign cout  = carry[N];
    assign c_msb = carry[MSB];
    // Sign-based rule: same-sign operands, result of the other sign.
    assign ovf   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/accum_addsub.sv
module accum_addsub #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld_b,
    input  logic         xfer,
    input  logic         add_en,
    input  logic         sub_en,
    input  logic [N-1:0] data_in,
    output logic [N-1:0] acc_q,
    output logic [N-1:0] b_q,
    output logic         ovf_q,
    output logic         cout_q
);
    import accum_pkg::*;

    op_e          op_sel;
    logic [N-1:0] b_eff;
    logic         cin;
    logic [N-1:0] sum;
    logic         add_cout;
    logic         add_cmsb;
    logic         add_ovf;
    acc_flags_t   flags;

    assign op_sel = pick_op(add_en, sub_en);

    acc_operand_gate #(.N(N)) u_gate (
        .b_in  (b_q),
        .op    (op_sel),
        .b_eff (b_eff),
        .cin   (cin)
    );

    acc_ripple_adder #(.N(N)) u_add (
        .a     (acc_q),
        .b     (b_eff),
        .cin   (cin),
        .sum   (sum),
        .cout  (add_cout),
        .c_msb (add_cmsb),
        .ovf   (add_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            b_q   <= '0;
            flags <= FLAGS_NONE;
        end else begin
            if (ld_b)
                b_q <= data_in;
            if (clr) begin
                acc_q <= '0;
                flags <= FLAGS_NONE;
            end else if (xfer) begin
                acc_q <= sum;
                flags <= '{ovf: add_ovf, cout: add_cout};
            end
        end
    end

    assign ovf_q  = flags.ovf;
    assign cout_q = flags.cout;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (acc_q == '0 && b_q == '0 && !ovf_q && !cout_q)); // R1
    AST_LOAD_B: assert property (@(posedge clk) disable iff (rst) ld_b |=> b_q == $past(data_in)); // R2
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst) (xfer && !clr && add_en && !sub_en) |=> acc_q == $past(acc_q + b_q)); // R3
    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst) (xfer && !clr && sub_en) |=> acc_q == $past(acc_q - b_q)); // R4
    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (rst) (xfer && !clr && !add_en && !sub_en) |=> (acc_q == $past(acc_q) && !ovf_q && !cout_q)); // R5
    AST_OVF_CARRY: assert property (@(posedge clk) disable iff (rst) (xfer && !clr) |=> ovf_q == $past(add_cmsb ^ add_cout)); // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst) clr |=> (acc_q == '0 && !ovf_q && !cout_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!xfer && !clr) |=> ($stable(acc_q) && $stable(ovf_q) && $stable(cout_q))); // R10

endmodule

// File: tb/sim_accum_addsub.sv
module sim_accum_addsub;
    localparam int N    = 4;
    localparam int MOD  = 1 << N;
    localparam int SMAX = (1 << (N - 1)) - 1;
    localparam int SMIN = -(1 << (N - 1));

    logic         clk = 1'b0;
    logic         rst, clr, ld_b, xfer, add_en, sub_en;
    logic [N-1:0] data_in;
    logic [N-1:0] acc_q, b_q;
    logic         ovf_q, cout_q;

    int checks = 0;
    int errors = 0;

    int m_a, m_b, m_ovf, m_cout;

    always #10 clk = ~clk;

    accum_addsub #(.N(N)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .ld_b(ld_b), .xfer(xfer),
        .add_en(add_en), .sub_en(sub_en), .data_in(data_in),
        .acc_q(acc_q), .b_q(b_q), .ovf_q(ovf_q), .cout_q(cout_q)
    );

    function automatic int to_signed(input int v);
        return (v >= (MOD / 2)) ? v - MOD : v;
    endfunction

    // Reference update from the requirements, integer arithmetic only.
    task automatic model_step(input bit r, input bit c, input bit l, input bit x,
                              input bit ad, input bit sb, input int d);
        int sa, sbv, res;
        if (r) begin
            m_a = 0; m_b = 0; m_ovf = 0; m_cout = 0;
            return;
        end
        if (c) begin
            m_a = 0; m_ovf = 0; m_cout = 0;
        end else if (x) begin
            sa  = to_signed(m_a);
            sbv = to_signed(m_b);
            if (sb) begin
                res    = sa - sbv;
                m_cout = (m_a >= m_b) ? 1 : 0;
                m_a    = (m_a - m_b + MOD) % MOD;
                m_ovf  = (res > SMAX || res < SMIN) ? 1 : 0;
            end else if (ad) begin
                res    = sa + sbv;
                m_cout = (m_a + m_b >= MOD) ? 1 : 0;
                m_a    = (m_a + m_b) % MOD;
                m_ovf  = (res > SMAX || res < SMIN) ? 1 : 0;
            end else begin
                m_ovf  = 0;
                m_cout = 0;
            end
        end
        if (l) m_b = d;
    endtask

    task automatic cyc(input bit r, input bit c, input bit l, input bit x,
                       input bit ad, input bit sb, input int d);
        rst = r; clr = c; ld_b = l; xfer = x; add_en = ad; sub_en = sb;
        data_in = d[N-1:0];
        model_step(r, c, l, x, ad, sb, d);
        @(negedge clk);
        rst = 0; clr = 0; ld_b = 0; xfer = 0; add_en = 0; sub_en = 0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        chk(req, "acc",  int'(acc_q),  m_a);
        chk(req, "b",    int'(b_q),    m_b);
        chk(req, "ovf",  int'(ovf_q),  m_ovf);
        chk(req, "cout", int'(cout_q), m_cout);
    endtask

    task automatic t_reset;
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R1", "acc", int'(acc_q), 0);
        chk("R1", "b", int'(b_q), 0);
        chk("R1", "flags", int'({ovf_q, cout_q}), 0);
    endtask

    task automatic t_example;
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b1001);
        chk("R2", "b after load", int'(b_q), 9);
        chk("R2", "acc after load", int'(acc_q), 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk("R3", "acc first", int'(acc_q), 9);
        cyc(0, 0, 1, 0, 0, 0, 4'b0101);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk("R3", "acc example", int'(acc_q), 4'b1110);
        chk("R3", "cout example", int'(cout_q), 0);
        chk("R7", "ovf example", int'(ovf_q), 0);
        chk_model("R3");
    endtask

    task automatic t_add_carry;
        cyc(0, 0, 1, 0, 0, 0, 4'b0011);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 14 + 3 = 17 -> 1, carry
        chk("R3", "acc wrap", int'(acc_q), 1);
        chk("R3", "cout wrap", int'(cout_q), 1);
        chk_model("R3");
    endtask

    task automatic t_sub;
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b1110);
        cyc(0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b0011);
        cyc(0, 0, 0, 1, 0, 1, 0);        // 14 - 3 = 11
        chk("R4", "acc sub", int'(acc_q), 11);
        chk("R4", "cout no borrow", int'(cout_q), 1);
        cyc(0, 0, 1, 0, 0, 0, 4'b1100);
        cyc(0, 0, 0, 1, 0, 1, 0);        // 11 - 12 = -1 -> 15, borrow
        chk("R4", "acc borrow", int'(acc_q), 15);
        chk("R4", "cout borrow", int'(cout_q), 0);
        chk_model("R4");
    endtask

    task automatic t_pass;
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R5", "acc pass", int'(acc_q), 15);
        chk("R5", "flags pass", int'({ovf_q, cout_q}), 0);
        chk_model("R5");
    endtask

    task automatic t_both;
        cyc(0, 0, 1, 0, 0, 0, 4'b0101);
        cyc(0, 0, 0, 1, 1, 1, 0);        // 15 - 5 = 10
        chk("R6", "acc both", int'(acc_q), 10);
        chk("R6", "cout both", int'(cout_q), 1);
        chk_model("R6");
    endtask

    task automatic t_overflow;
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b0111);
        cyc(0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b0001);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 7 + 1 = 8 overflow
        chk("R7", "acc pos ovf", int'(acc_q), 8);
        chk("R7", "ovf pos", int'(ovf_q), 1);
        cyc(0, 0, 1, 0, 0, 0, 4'b1111);
        cyc(0, 0, 0, 1, 1, 0, 0);        // -8 + -1 overflow
        chk("R7", "acc neg ovf", int'(acc_q), 7);
        chk("R7", "ovf neg", int'(ovf_q), 1);
        chk("R7", "cout neg", int'(cout_q), 1);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 4'b1000);
        cyc(0, 0, 0, 1, 0, 1, 0);        // 0 - (-8) overflow
        chk("R7", "acc sub ovf", int'(acc_q), 8);
        chk("R7", "ovf sub", int'(ovf_q), 1);
        cyc(0, 0, 1, 0, 0, 0, 4'b0001);
        cyc(0, 0, 0, 1, 0, 1, 0);        // -8 - 1 overflow
        chk("R7", "ovf sub neg", int'(ovf_q), 1);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 7 + 1 with fresh flags
        cyc(0, 0, 1, 0, 0, 0, 4'b1111);
        cyc(0, 0, 0, 1, 1, 0, 0);        // -8 + -1 again
        cyc(0, 0, 1, 0, 0, 0, 4'b0001);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 7 + 1: ovf; then check no ovf case
        cyc(0, 0, 1, 0, 0, 0, 4'b1111);
        cyc(0, 0, 0, 1, 1, 0, 0);        // -8 + -1 -> 7, ovf
        cyc(0, 0, 1, 0, 0, 0, 4'b1111);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 7 + -1 = 6, opposite signs
        chk("R7", "acc mixed", int'(acc_q), 6);
        chk("R7", "ovf mixed", int'(ovf_q), 0);
        chk_model("R7");
    endtask

    task automatic t_clr_vs_xfer;
        cyc(0, 0, 1, 0, 0, 0, 4'b0100);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 6 + 4 = 10
        cyc(0, 0, 1, 0, 0, 0, 4'b1001);
        cyc(0, 0, 0, 1, 1, 0, 0);        // 10 + 9 = 19 -> 3, carry
        chk("R8", "cout before clr", int'(cout_q), 1);
        cyc(0, 1, 0, 1, 1, 0, 0);
        chk("R8", "acc clr wins", int'(acc_q), 0);
        chk("R8", "flags clr wins", int'({ovf_q, cout_q}), 0);
        chk("R8", "b kept", int'(b_q), 9);
        chk_model("R8");
    endtask

    task automatic t_load_vs_xfer;
        cyc(0, 0, 0, 1, 1, 0, 0);        // 0 + 9 = 9
        cyc(0, 0, 1, 1, 1, 0, 4'b0010);  // uses old 9: 18 -> 2, carry
        chk("R9", "acc old b", int'(acc_q), 2);
        chk("R9", "b new", int'(b_q), 2);
        chk("R9", "cout old b", int'(cout_q), 1);
        chk_model("R9");
    endtask

    task automatic t_idle;
        cyc(0, 0, 0, 0, 1, 1, 0);        // mode only, no strobe
        cyc(0, 0, 1, 0, 1, 0, 4'b0111);  // load with mode, no transfer
        chk("R10", "acc held", int'(acc_q), 2);
        chk("R10", "cout held", int'(cout_q), 1);
        chk("R2", "b loaded", int'(b_q), 7);
        chk_model("R10");
    endtask

    bit done = 0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; clr = 0; ld_b = 0; xfer = 0; add_en = 0; sub_en = 0; data_in = '0;
        m_a = 0; m_b = 0; m_ovf = 0; m_cout = 0;
        @(negedge clk);
        t_reset();
        t_example();
        t_add_carry();
        t_sub();
        t_pass();
        t_both();
        t_overflow();
        t_clr_vs_xfer();
        t_load_vs_xfer();
        t_idle();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule